// File: doc/BRIEF.md
# Line Voltage Sag Detector

The block watches a stream of signed line-voltage samples and raises a sticky sag flag when the voltage magnitude stays under a programmed level for a programmed number of whole line cycles. An external zero-crossing pulse marks each line-cycle boundary. The detector counts these pulses only while the most recent sample is under the level.

The flag drops by itself as soon as a valid sample reaches the level again. Host software can also clear it with a write-one-to-clear pulse. An interrupt request follows the flag whenever the sag interrupt enable is set.

The cycle setting holds one more than the number of full cycles wanted. This is because the first boundary after the drop only opens the first full cycle.

Top module: `sag_detector`

## Requirements
- R1: The magnitude is the upper 16 bits of the absolute value of the 24-bit two's complement sample. The most negative code (0x800000) saturates to 0x7FFFFF, which gives a magnitude of 0x7FFF. A sample is "below" when the level is strictly greater than its magnitude. A magnitude equal to the level is not below.
- R2: A level of 0x0000 or 0x0001 never detects a sag, whatever the sample.
- R3: Each zero-crossing pulse counts while the most recent valid sample (or one in the same cycle) is below. The flag rises in the cycle after the pulse that brings the count to the cycle setting N, which is the end of N-1 full cycles.
- R4: Cycle settings 0 and 1 act exactly as setting 2.
- R5: A valid sample at or above the level clears the count, and the flag reads 0 in the following cycle.
- R6: sag_irq is high exactly when sag_flag and sag_irq_en are both high, and it does not wait for a clock edge.
- R7: A sag_flag_clr pulse clears the flag. The flag stays clear for the rest of that sag, however many pulses follow. If the set and the clear arrive in the same cycle, the set wins.
- R8: After a synchronous active-low reset the flag and interrupt read 0, and the count and held condition are cleared.
- R9: The count saturates at its maximum, so a cycle setting of 255 fires on the 255th pulse and does not fire on the 254th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed voltage sample |
| zc_pulse | input | 1 | One-cycle line-cycle boundary pulse |
| sag_level | input | 16 | Sag threshold |
| sag_cycles | input | 8 | Cycle setting, one more than full cycles wanted |
| sag_irq_en | input | 1 | Sag interrupt enable |
| sag_flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| sag_flag | output | 1 | Sticky sag flag |
| sag_irq | output | 1 | Interrupt request |

## Verification
The bench uses the default widths: a 24-bit sample, a 16-bit level and an 8-bit count. With these widths the saturation of the most negative code can be told apart from a plain absolute value, using a level of 0x8000. The largest cycle setting, 255, can be run in full, which puts both the count saturation and the one-before-target case within reach.

// File: rtl/sag_pkg.sv
// Shared constants for the sag detector.
// Assumes nothing beyond elaboration-time use.
package sag_pkg;
    // smallest legal cycle setting; smaller settings are promoted to it
    localparam int unsigned CYC_MIN = 2;
    // levels at or under this value place the threshold at zero
    localparam int unsigned LVL_DEAD = 1;
endpackage

// File: rtl/sag_level_cmp.sv
// Magnitude extraction and level comparison.
// Takes the absolute value of a two's complement sample, saturates the most
// negative code, keeps the upper LVL_W bits and compares them with the level.
// Assumes SMP_W >= LVL_W. Purely combinational.
module sag_level_cmp #(
    parameter int SMP_W = 24,
    parameter int LVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [LVL_W-1:0] sag_level,
    output logic [LVL_W-1:0] smp_mag,
    output logic             smp_below
);
    import sag_pkg::*;

    localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] MOST_POS = {1'b0, {(SMP_W-1){1'b1}}};

    logic [SMP_W-1:0] abs_val;

    // absolute value with saturation of the most negative code
    always_comb begin
        if (smp_data == MOST_NEG)
            abs_val = MOST_POS;
        else if (smp_data[SMP_W-1])
            abs_val = (~smp_data) + 1'b1;
        else
            abs_val = smp_data;
    end

    // keep the upper bits and compare against the level
    always_comb begin
        smp_mag   = abs_val[SMP_W-1 -: LVL_W];
        smp_below = (sag_level > LVL_W'(LVL_DEAD)) && (sag_level > smp_mag);
    end

    // R2: a dead level never reports a below sample
    a_r2_dead_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_level <= LVL_W'(LVL_DEAD)) |-> !smp_below);
    // R1: the magnitude never shows the sign bit position set
    a_r1_mag_range: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_mag[LVL_W-1]);
endmodule

// File: rtl/sag_cycle_ctr.sv
// Line-cycle counter for the sag detector.
// Holds the latest below condition and counts zero-crossing pulses while it
// holds. Emits a one-cycle hit when the count reaches the effective setting.
// Assumes zc_pulse is at most one cycle wide per boundary.
module sag_cycle_ctr #(
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_below,
    input  logic             zc_pulse,
    input  logic [CYC_W-1:0] sag_cycles,
    output logic             cyc_hit,
    output logic             cond_now
);
    import sag_pkg::*;

    localparam logic [CYC_W-1:0] CNT_MAX = {CYC_W{1'b1}};

    logic [CYC_W-1:0] cnt_q;
    logic             below_q;
    logic [CYC_W-1:0] target;
    logic             inc;
    logic [CYC_W:0]   cnt_plus;

    // condition seen this cycle: fresh sample wins over the held one
    always_comb begin
        cond_now = smp_valid ? smp_below : below_q;
        target   = (sag_cycles < CYC_W'(CYC_MIN)) ? CYC_W'(CYC_MIN) : sag_cycles;
        inc      = zc_pulse && cond_now;
        cnt_plus = {1'b0, cnt_q} + 1'b1;
        cyc_hit  = inc && (cnt_q != CNT_MAX) && (cnt_plus == {1'b0, target});
    end

    // hold the condition of the most recent valid sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            below_q <= 1'b0;
        else if (smp_valid)
            below_q <= smp_below;
    end

    // count boundaries while below, clear on recovery, saturate at max
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!cond_now)
            cnt_q <= '0;
        else if (inc && (cnt_q != CNT_MAX))
            cnt_q <= cnt_plus[CYC_W-1:0];
    end

    // R9: a saturated count stays saturated while the condition holds
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && cond_now) |=> (cnt_q == CNT_MAX));
    // R5: a valid sample that is not below empties the count
    a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_below) |=> (cnt_q == '0));
    // R4: a hit never arrives before two boundaries have been counted
    a_r4_min_two: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_hit |-> (cnt_q != '0));
endmodule

// File: rtl/sag_flag_ctl.sv
// Sticky sag flag and interrupt request.
// Sets on a counter hit, clears on a recovered sample or a host clear pulse.
// A hit in the same cycle as a host clear wins. Assumes sag_flag_clr is a pulse.
module sag_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_hit,
    input  logic recover,
    input  logic sag_flag_clr,
    input  logic sag_irq_en,
    output logic sag_flag,
    output logic sag_irq
);
    logic flag_q;

    // flag update: set beats host clear, recovery clears
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (cyc_hit)
            flag_q <= 1'b1;
        else if (recover || sag_flag_clr)
            flag_q <= 1'b0;
    end

    // outputs
    always_comb begin
        sag_flag = flag_q;
        sag_irq  = flag_q && sag_irq_en;
    end

    // R3: the flag only rises after a counter hit
    a_r3_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cyc_hit));
    // R7: a host clear without a hit leaves the flag low
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_flag_clr && !cyc_hit) |=> !flag_q);
    // R5: recovery leaves the flag low
    a_r5_recover: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> !flag_q);
endmodule

// File: rtl/sag_detector.sv
// Line voltage sag detector top.
// Chains the magnitude comparator, the cycle counter and the flag control.
// Assumes zero crossings and filtering are produced outside the block.
module sag_detector #(
    parameter int SMP_W = 24,
    parameter int LVL_W = 16,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             zc_pulse,
    input  logic [LVL_W-1:0] sag_level,
    input  logic [CYC_W-1:0] sag_cycles,
    input  logic             sag_irq_en,
    input  logic             sag_flag_clr,
    output logic             sag_flag,
    output logic             sag_irq
);
    logic [LVL_W-1:0] smp_mag;
    logic             smp_below;
    logic             cyc_hit;
    logic             cond_now;
    logic             recover;

    sag_level_cmp #(.SMP_W(SMP_W), .LVL_W(LVL_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_data  (smp_data),
        .sag_level (sag_level),
        .smp_mag   (smp_mag),
        .smp_below (smp_below)
    );

    sag_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_below  (smp_below),
        .zc_pulse   (zc_pulse),
        .sag_cycles (sag_cycles),
        .cyc_hit    (cyc_hit),
        .cond_now   (cond_now)
    );

    // a valid sample at or above the level ends the sag
    always_comb recover = smp_valid && !smp_below;

    sag_flag_ctl u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_hit      (cyc_hit),
        .recover      (recover),
        .sag_flag_clr (sag_flag_clr),
        .sag_irq_en   (sag_irq_en),
        .sag_flag     (sag_flag),
        .sag_irq      (sag_irq)
    );

    // R3: a hit can only come from a boundary under a below condition
    a_r3_hit_cond: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_hit |-> (zc_pulse && cond_now));
    // R6: with the enable low the request stays low
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !sag_irq_en |-> !sag_irq);
endmodule

// File: tb/sim_sag_detector.sv
`timescale 1ns/100ps
module sim_sag_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        zc_pulse = 1'b0;
    logic [15:0] sag_level = '0;
    logic [7:0]  sag_cycles = 8'd4;
    logic        sag_irq_en = 1'b0;
    logic        sag_flag_clr = 1'b0;
    logic        sag_flag;
    logic        sag_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sag_detector u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .zc_pulse(zc_pulse), .sag_level(sag_level), .sag_cycles(sag_cycles),
        .sag_irq_en(sag_irq_en), .sag_flag_clr(sag_flag_clr),
        .sag_flag(sag_flag), .sag_irq(sag_irq)
    );

    // {level, cycles, sample, boundaries, expected flag, requirement}
    localparam int NV = 15;
    localparam logic [61:0] VEC [NV] = '{
        {16'h1000, 8'd4,   24'h000100, 9'd3,   1'b0, 4'd3},
        {16'h1000, 8'd4,   24'h000100, 9'd4,   1'b1, 4'd3},
        {16'h1000, 8'd4,   24'hFFFF00, 9'd4,   1'b1, 4'd1},
        {16'h1000, 8'd4,   24'h100000, 9'd6,   1'b0, 4'd1},
        {16'h1000, 8'd2,   24'h0FFFFF, 9'd1,   1'b0, 4'd3},
        {16'h1000, 8'd2,   24'h0FFFFF, 9'd2,   1'b1, 4'd3},
        {16'h1000, 8'd0,   24'h000000, 9'd1,   1'b0, 4'd4},
        {16'h1000, 8'd0,   24'h000000, 9'd2,   1'b1, 4'd4},
        {16'h1000, 8'd1,   24'h000000, 9'd2,   1'b1, 4'd4},
        {16'h0001, 8'd2,   24'h000000, 9'd10,  1'b0, 4'd2},
        {16'h0000, 8'd2,   24'h000000, 9'd10,  1'b0, 4'd2},
        {16'h0002, 8'd2,   24'h000000, 9'd2,   1'b1, 4'd2},
        {16'h8000, 8'd2,   24'h800000, 9'd2,   1'b1, 4'd1},
        {16'hFFFF, 8'd255, 24'h000000, 9'd254, 1'b0, 4'd9},
        {16'hFFFF, 8'd255, 24'h000000, 9'd255, 1'b1, 4'd9}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic sample(input logic [23:0] v);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic boundary();
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic quiesce();
        sag_level = 16'h0000;
        sample(24'h000000);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 flag", sag_flag, 1'b0);
        chk("R8 irq", sag_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        boundary(); boundary();
        chk("R8 no count before sample", sag_flag, 1'b0);

        // vector table walk
        sag_irq_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            quiesce();
            sag_level  = VEC[i][61:46];
            sag_cycles = VEC[i][45:38];
            sample(VEC[i][37:14]);
            for (int k = 0; k < int'(VEC[i][13:5]); k++) boundary();
            chk($sformatf("R%0d vec%0d flag", VEC[i][3:0], i), sag_flag, VEC[i][4]);
            chk($sformatf("R6 vec%0d irq", i), sag_irq, VEC[i][4]);
        end

        // R6: enable gates the request, flag stays
        quiesce();
        sag_level = 16'h1000; sag_cycles = 8'd2;
        sample(24'h000010);
        boundary(); boundary();
        sag_irq_en = 1'b0;
        #1;
        chk("R6 irq off", sag_irq, 1'b0);
        chk("R6 flag kept", sag_flag, 1'b1);
        sag_irq_en = 1'b1;
        #1;
        chk("R6 irq on", sag_irq, 1'b1);

        // R7: host clear holds for the rest of the sag
        @(negedge clk);
        sag_flag_clr = 1'b1;
        @(negedge clk);
        sag_flag_clr = 1'b0;
        chk("R7 cleared", sag_flag, 1'b0);
        boundary(); boundary(); boundary();
        sample(24'h000010);
        boundary();
        chk("R7 stays clear", sag_flag, 1'b0);

        // R5: recovery clears the flag one cycle later
        quiesce();
        sag_level = 16'h1000; sag_cycles = 8'd2;
        sample(24'h000010);
        boundary(); boundary();
        chk("R5 set before recovery", sag_flag, 1'b1);
        sample(24'h7FFFFF);
        chk("R5 recovery clears", sag_flag, 1'b0);
        boundary();
        chk("R5 count restarted", sag_flag, 1'b0);
        sample(24'h000010);
        boundary();
        chk("R5 one boundary not enough", sag_flag, 1'b0);
        boundary();
        chk("R3 resets again", sag_flag, 1'b1);

        // R7: set wins over a clear in the same cycle
        quiesce();
        sag_level = 16'h1000; sag_cycles = 8'd2;
        sample(24'h000010);
        boundary();
        zc_pulse = 1'b1; sag_flag_clr = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0; sag_flag_clr = 1'b0;
        chk("R7 set wins", sag_flag, 1'b1);

        // R3: sample and boundary in the same cycle use the fresh sample
        quiesce();
        sag_level = 16'h1000; sag_cycles = 8'd2;
        smp_valid = 1'b1; smp_data = 24'h000010; zc_pulse = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; zc_pulse = 1'b0;
        boundary();
        chk("R3 same-cycle sample", sag_flag, 1'b1);

        // R8: reset mid-sag
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears flag", sag_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule